// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is a slave-only SMBus target that holds the eight configuration bytes of a differential clock buffer. It samples the serial clock and data lines with the system clock, pulls the data line low for acknowledges and read data, and answers at one of eight bus addresses chosen by three strap pins. Bytes 0, 1 and 2 drive the output-control logic directly: gear ratio, per-output enables, loop mode and bandwidth. Bytes 3 and 4 report pin levels. Byte 5 carries a vendor and revision code, byte 6 a device identifier, and byte 7 a writable byte count.

A host reaches the registers in one of two ways. A single-byte access uses a command byte with its top bit set, where bits 6:0 hold the register offset. A block access uses command 0x00. A block write sends a byte count and then data bytes into registers 0 upward. A block read first returns the byte-count register and then registers 0 upward. The host ends any read with a NACK. The target then releases the data line and waits for a STOP or a repeated START. Both lines are plain level pins with no handshake. The only data flow is the serial one, and it is paced entirely by the host's clock.

Top module: `smbus_cfg_regs`

## Requirements
- R1: The target acknowledges an address byte only when its bits 7:4 equal 4'b1101 and its bits 3:1 equal the strap pins. Bit 0 selects the direction (0 write, 1 read). After a mismatch the target does not drive SDA until the next START.
- R2: The target changes its SDA drive only while the sampled SCL is low. It releases SDA after each acknowledge clock of a received byte.
- R3: A command byte with bit 7 set starts a single-byte access at offset bits 6:0. One data byte is written there. Any further data bytes are acknowledged and discarded.
- R4: Command 0x00 starts a block write. The next byte is a count N, and the following N data bytes go to registers 0, 1, 2 and so on. Bytes beyond N are acknowledged and discarded.
- R5: A block read (command 0x00, repeated START, address with read bit) first returns the value of register 7. It then returns registers 0 upward for as long as the host acknowledges.
- R6: A single-byte read returns the register at the commanded offset. Each further acknowledged byte comes from the next offset.
- R7: Writes to registers 3 to 6, or to offsets above 7, are acknowledged and leave every register unchanged. Reads of offsets above 7 return 0x00.
- R8: Register 3 equals enable pins 7:0 (live). Register 4 is {latched freq select, latched bandwidth pin, latched strap bit 2, 2'b00, enable pins 10:8}, with the three latches captured during reset. Register 5 reads 0x00 and register 6 reads 0x0C.
- R9: Reset values depend on the frequency-select input fs. Register 0 resets to {3'b111, fs, fs, 1'b0, ~fs, 1'b1}, which is 0xE3 for fs=0 and 0xF9 for fs=1. Register 1 resets to 0xFF, register 2 to 0xEF and register 7 to 0x07.
- R10: When the host NACKs a read byte, the target leaves SDA released for all further clocks until a STOP or START.
- R11: A command byte that is neither 0x00 nor has bit 7 set is not acknowledged.
- R12: The outputs cfg0_o, cfg1_o and cfg2_o show registers 0, 1 and 2 and change only through a bus write to that register.
- R13: Register 7 is read/write and changes only through a bus write to offset 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset; the strap latches are captured while it is low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_drive_o | output | 1 | 1 pulls SDA low (open-drain) |
| strap_addr_i | input | 3 | Address strap pins; bit 2 also reports loop bypass |
| freq_sel_i | input | 1 | Frequency-select input, latched at reset |
| bw_sel_i | input | 1 | Bandwidth-select pin, latched at reset |
| oe_pins_n_i | input | 11 | Active-low output-enable pin levels |
| cfg0_o | output | 8 | Register 0: gear ratio and group ratio selects |
| cfg1_o | output | 8 | Register 1: enables for outputs 0 to 7 |
| cfg2_o | output | 8 | Register 2: enables for outputs 8 to 11, loop mode, bandwidth, power-down drive |

## Verification
The bench sweeps every strap setting against every address, so a decoder that ignores a strap bit or the upper nibble acknowledges a foreign address. Block writes send one byte more than the count, so a design that ignores the count overwrites register 2. Block reads use counts of 4 and 8 and add a clock after the host NACK, so a design that keeps shifting after the NACK pulls SDA low on that clock. Writes to read-only and out-of-range offsets, an unsupported command, and a second reset with the other frequency select check that the registers stay put, that the command is refused, and that register 0 and the reset latches take the right values.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;
  localparam int REG_NUM = 8;
  localparam int PTR_W = 7;
  localparam int PIN_NUM = 11;
  localparam logic [3:0] ADDR_HI = 4'hD;
  localparam logic [7:0] DEVICE_ID = 8'h0C;
  localparam logic [7:0] VENDOR_REV = 8'h00;
  localparam logic [7:0] COUNT_RST = 8'h07;
  localparam logic [7:0] CFG1_RST = 8'hFF;
  localparam logic [7:0] CFG2_RST = 8'hEF;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_COUNT, PH_WDATA, PH_RDATA, PH_SKIP
  } phase_t;

  function automatic logic [7:0] cfg0_reset(input logic fs);
    return {3'b111, fs, fs, 1'b0, ~fs, 1'b1};
  endfunction
endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/smbus_cfg_regfile.sv
module smbus_cfg_regfile
  import smbus_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [PTR_W-1:0]   wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [PTR_W-1:0]   rd_addr_i,
  output logic [7:0]         rd_data_o,
  input  logic               freq_sel_i,
  input  logic               bw_sel_i,
  input  logic               bypass_i,
  input  logic [PIN_NUM-1:0] oe_pins_n_i,
  output logic [7:0]         cfg0_o,
  output logic [7:0]         cfg1_o,
  output logic [7:0]         cfg2_o,
  output logic [7:0]         count_o
);
  logic [7:0] cfg0_q, cfg1_q, cfg2_q, count_q;
  logic fs_l, bw_l, byp_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg0_q  <= cfg0_reset(freq_sel_i);
      cfg1_q  <= CFG1_RST;
      cfg2_q  <= CFG2_RST;
      count_q <= COUNT_RST;
      fs_l    <= freq_sel_i;
      bw_l    <= bw_sel_i;
      byp_l   <= bypass_i;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        7'd0:    cfg0_q  <= wr_data_i;
        7'd1:    cfg1_q  <= wr_data_i;
        7'd2:    cfg2_q  <= wr_data_i;
        7'd7:    count_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr_i)
      7'd0:    rd_data_o = cfg0_q;
      7'd1:    rd_data_o = cfg1_q;
      7'd2:    rd_data_o = cfg2_q;
      7'd3:    rd_data_o = oe_pins_n_i[7:0];
      7'd4:    rd_data_o = {fs_l, bw_l, byp_l, 2'b00, oe_pins_n_i[PIN_NUM-1:8]};
      7'd5:    rd_data_o = VENDOR_REV;
      7'd6:    rd_data_o = DEVICE_ID;
      7'd7:    rd_data_o = count_q;
      default: rd_data_o = 8'h00;
    endcase
  end

  assign cfg0_o  = cfg0_q;
  assign cfg1_o  = cfg1_q;
  assign cfg2_o  = cfg2_q;
  assign count_o = count_q;

  assert_count_write_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_q) |-> $past(wr_en_i && wr_addr_i == 7'd7));
  assert_cfg1_write_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg1_q) |-> $past(wr_en_i && wr_addr_i == 7'd1));
  assert_cfg2_write_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg2_q) |-> $past(wr_en_i && wr_addr_i == 7'd2));
endmodule

// File: rtl/smbus_target_fsm.sv
module smbus_target_fsm
  import smbus_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [2:0]       strap_i,
  input  logic [7:0]       rd_data_i,
  input  logic [7:0]       count_i,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_drive_o
);
  localparam logic [3:0] CNT_LAST = 4'd8;
  localparam logic [3:0] CNT_ACK  = 4'd9;

  phase_t phase, pend;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, remain;
  logic [PTR_W-1:0] ptr;
  logic blk, host_ack, addr_hit, rx_phase;

  assign addr_hit  = rx_sh[7:1] == {ADDR_HI, strap_i};
  assign rx_phase  = phase inside {PH_ADDR, PH_CMD, PH_COUNT, PH_WDATA};
  assign rd_addr_o = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE; pend <= PH_IDLE; bit_cnt <= '0;
      rx_sh <= '0; tx_sh <= '0; remain <= '0; ptr <= '0;
      blk <= 1'b0; host_ack <= 1'b0; sda_drive_o <= 1'b0;
      wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        phase <= PH_ADDR; bit_cnt <= '0; sda_drive_o <= 1'b0;
      end else if (stop_i) begin
        phase <= PH_IDLE; bit_cnt <= '0; sda_drive_o <= 1'b0;
      end else if (phase == PH_RDATA) begin
        if (scl_rise_i) begin
          if (bit_cnt < CNT_LAST) bit_cnt <= bit_cnt + 4'd1;
          else if (bit_cnt == CNT_LAST) begin
            host_ack <= ~sda_i;
            bit_cnt  <= CNT_ACK;
          end
        end else if (scl_fall_i) begin
          if (bit_cnt == CNT_ACK) begin
            if (host_ack) begin
              tx_sh <= rd_data_i; sda_drive_o <= ~rd_data_i[7];
              ptr <= ptr + 7'd1; bit_cnt <= '0;
            end else begin
              phase <= PH_SKIP; sda_drive_o <= 1'b0;
            end
          end else if (bit_cnt == CNT_LAST) begin
            sda_drive_o <= 1'b0;
          end else if (bit_cnt != 4'd0) begin
            tx_sh <= {tx_sh[6:0], 1'b0};
            sda_drive_o <= ~tx_sh[6];
          end
        end
      end else if (rx_phase) begin
        if (scl_rise_i && bit_cnt < CNT_LAST) begin
          rx_sh   <= {rx_sh[6:0], sda_i};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall_i && bit_cnt == CNT_LAST) begin
          bit_cnt <= CNT_ACK;
          case (phase)
            PH_ADDR: begin
              if (addr_hit) begin
                sda_drive_o <= 1'b1;
                pend <= rx_sh[0] ? PH_RDATA : PH_CMD;
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_CMD: begin
              if (rx_sh == 8'h00) begin
                blk <= 1'b1; ptr <= '0; pend <= PH_COUNT; sda_drive_o <= 1'b1;
              end else if (rx_sh[7]) begin
                blk <= 1'b0; ptr <= rx_sh[6:0]; remain <= 8'd1;
                pend <= PH_WDATA; sda_drive_o <= 1'b1;
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_COUNT: begin
              remain <= rx_sh; pend <= PH_WDATA; sda_drive_o <= 1'b1;
            end
            default: begin
              sda_drive_o <= 1'b1; pend <= PH_WDATA;
              if (remain != 8'd0) begin
                wr_en_o <= 1'b1; wr_addr_o <= ptr; wr_data_o <= rx_sh;
                ptr <= ptr + 7'd1; remain <= remain - 8'd1;
              end
            end
          endcase
        end else if (scl_fall_i && bit_cnt == CNT_ACK) begin
          bit_cnt <= '0;
          phase   <= pend;
          if (pend == PH_RDATA) begin
            if (blk) begin
              tx_sh <= count_i; sda_drive_o <= ~count_i[7]; ptr <= '0;
            end else begin
              tx_sh <= rd_data_i; sda_drive_o <= ~rd_data_i[7]; ptr <= ptr + 7'd1;
            end
          end else begin
            sda_drive_o <= 1'b0;
          end
        end
      end
    end
  end

  assert_drive_when_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_o) |-> !$past(scl_i));
  assert_addr_miss_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && scl_fall_i && bit_cnt == CNT_LAST && !addr_hit && !start_i && !stop_i)
      |=> !sda_drive_o);
  assert_skip_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !sda_drive_o);
  assert_write_from_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(phase == PH_WDATA));
endmodule

// File: rtl/smbus_cfg_regs.sv
module smbus_cfg_regs
  import smbus_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_drive_o,
  input  logic [2:0]         strap_addr_i,
  input  logic               freq_sel_i,
  input  logic               bw_sel_i,
  input  logic [PIN_NUM-1:0] oe_pins_n_i,
  output logic [7:0]         cfg0_o,
  output logic [7:0]         cfg1_o,
  output logic [7:0]         cfg2_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data, count_val;

  smbus_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  smbus_target_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_ev), .stop_i(stop_ev),
    .strap_i(strap_addr_i), .rd_data_i(rd_data), .count_i(count_val),
    .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sda_drive_o(sda_drive_o)
  );

  smbus_cfg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .freq_sel_i(freq_sel_i), .bw_sel_i(bw_sel_i),
    .bypass_i(strap_addr_i[2]), .oe_pins_n_i(oe_pins_n_i),
    .cfg0_o(cfg0_o), .cfg1_o(cfg1_o), .cfg2_o(cfg2_o), .count_o(count_val)
  );
endmodule

// File: tb/smbus_cfg_regs_bench.sv
module smbus_cfg_regs_bench;
  localparam int Q = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_drive, sda_bus;
  logic [2:0] strap = 3'd5;
  logic fs = 1'b0, bw = 1'b1;
  logic [10:0] pins = 11'h5A3;
  logic [7:0] cfg0, cfg1, cfg2;
  int n_checks = 0, n_err = 0;
  logic [7:0] m0, m1, m2, m7;
  logic fs_l, bw_l, byp_l;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [10];

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_drive;

  smbus_cfg_regs u_smbus_cfg_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_drive_o(sda_drive),
    .strap_addr_i(strap), .freq_sel_i(fs), .bw_sel_i(bw), .oe_pins_n_i(pins),
    .cfg0_o(cfg0), .cfg1_o(cfg1), .cfg2_o(cfg2)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input int off);
    case (off)
      0: return m0;
      1: return m1;
      2: return m2;
      3: return pins[7:0];
      4: return {fs_l, bw_l, byp_l, 2'b00, pins[10:8]};
      5: return 8'h00;
      6: return 8'h0C;
      7: return m7;
      default: return 8'h00;
    endcase
  endfunction

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic r);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); r = sda_bus; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic xstart();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic xstop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) sbit(d[i], r);
    sbit(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin sbit(1'b1, r); d[i] = r; end
    sbit(~ack, r);
  endtask

  task automatic do_reset(input logic f, input logic b, input logic [2:0] s);
    fs = f; bw = b; strap = s; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    fs_l = f; bw_l = b; byp_l = s[2];
    m0 = {3'b111, f, f, 1'b0, ~f, 1'b1}; m1 = 8'hFF; m2 = 8'hEF; m7 = 8'h07;
  endtask

  // write transaction: command then n data bytes from wbuf; all_ack is AND of acks
  task automatic wr_seq(input logic [7:0] cmd, input int n, output logic all_ack);
    logic a;
    xstart();
    send_byte({4'hD, strap, 1'b0}, a); all_ack = a;
    send_byte(cmd, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], a); all_ack &= a; end
    xstop();
  endtask

  // read transaction: command, repeated start, n bytes into rbuf, last NACKed
  task automatic rd_seq(input logic [7:0] cmd, input int n, output logic all_ack, output logic idle_bit);
    logic a, r;
    xstart();
    send_byte({4'hD, strap, 1'b0}, a); all_ack = a;
    send_byte(cmd, a); all_ack &= a;
    xstart();
    send_byte({4'hD, strap, 1'b1}, a); all_ack &= a;
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    sbit(1'b1, r);
    idle_bit = r;
    xstop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    logic ok, idle;
    do_reset(1'b0, 1'b1, 3'd5);
    // R9 reset values, R12 outputs
    check8("R9 cfg0 reset fs=0", cfg0, 8'hE3);
    check8("R9 cfg1 reset", cfg1, 8'hFF);
    check8("R9 cfg2 reset", cfg2, 8'hEF);
    check8("R2 idle release", {7'd0, sda_drive}, 8'h00);

    // R6 R8 R9 single reads of every offset plus out-of-range (R7)
    for (int off = 0; off < 10; off++) begin
      rd_seq({1'b1, 7'(off)}, 1, ok, idle);
      check8($sformatf("R6 ack read off %0d", off), {7'd0, ok}, 8'h01);
      check8($sformatf("R8 read off %0d", off), rbuf[0], model(off));
    end

    // R1 exhaustive address sweep
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        xstart();
        send_byte({4'hD, 3'(a), 1'b0}, ok);
        check8($sformatf("R1 strap %0d addr %0d", s, a), {7'd0, ok}, {7'd0, a == s});
        send_byte(8'h81, ok);
        check8($sformatf("R1 follow byte strap %0d addr %0d", s, a), {7'd0, ok}, {7'd0, a == s});
        xstop();
      end
      xstart();
      send_byte({4'hC, 3'(s), 1'b0}, ok);
      check8("R1 upper nibble miss", {7'd0, ok}, 8'h00);
      xstop();
    end
    strap = 3'd5;

    // R3 single write with extra byte discarded
    wbuf[0] = 8'h3C; wbuf[1] = 8'h55;
    wr_seq(8'h81, 2, ok);
    m1 = 8'h3C;
    check8("R3 all acked", {7'd0, ok}, 8'h01);
    check8("R3 R12 cfg1 written", cfg1, m1);
    check8("R3 extra byte dropped cfg2", cfg2, m2);

    // R7 read-only and out-of-range writes
    wbuf[0] = 8'hFF; wr_seq(8'h86, 1, ok);
    check8("R7 ro write acked", {7'd0, ok}, 8'h01);
    wbuf[0] = 8'h11; wr_seq(8'h83, 1, ok);
    wbuf[0] = 8'h22; wr_seq(8'h8A, 1, ok);
    check8("R7 oor write acked", {7'd0, ok}, 8'h01);
    rd_seq(8'h86, 1, ok, idle);
    check8("R7 reg6 unchanged", rbuf[0], 8'h0C);
    rd_seq(8'h83, 1, ok, idle);
    check8("R7 reg3 unchanged", rbuf[0], model(3));
    check8("R7 cfg0 unchanged", cfg0, m0);
    check8("R7 cfg1 unchanged", cfg1, m1);
    check8("R7 cfg2 unchanged", cfg2, m2);

    // R4 block write, count 2, third byte dropped
    wbuf[0] = 8'd2; wbuf[1] = 8'hA1; wbuf[2] = 8'hB2; wbuf[3] = 8'hC3;
    wr_seq(8'h00, 4, ok);
    m0 = 8'hA1; m1 = 8'hB2;
    check8("R4 block acked", {7'd0, ok}, 8'h01);
    check8("R4 cfg0", cfg0, m0);
    check8("R4 cfg1", cfg1, m1);
    check8("R4 beyond count cfg2", cfg2, m2);

    // R13 byte count write, R5 R10 block reads with counts 4 and 8
    for (int c = 4; c <= 8; c += 4) begin
      wbuf[0] = 8'(c); wr_seq(8'h87, 1, ok);
      m7 = 8'(c);
      rd_seq(8'h87, 1, ok, idle);
      check8("R13 count readback", rbuf[0], m7);
      rd_seq(8'h00, c + 1, ok, idle);
      check8("R5 block read acked", {7'd0, ok}, 8'h01);
      check8("R5 count byte", rbuf[0], m7);
      for (int i = 0; i < c; i++)
        check8($sformatf("R5 block byte %0d", i), rbuf[i + 1], model(i));
      check8("R10 released after nack", {7'd0, idle}, 8'h01);
    end

    // R6 sequential single read from offset 5
    rd_seq(8'h85, 3, ok, idle);
    check8("R6 seq off5", rbuf[0], model(5));
    check8("R6 seq off6", rbuf[1], model(6));
    check8("R6 seq off7", rbuf[2], model(7));

    // R11 unsupported command refused
    xstart();
    send_byte({4'hD, strap, 1'b0}, ok);
    send_byte(8'h40, ok);
    check8("R11 cmd 40 nack", {7'd0, ok}, 8'h00);
    xstop();

    // R8 live pins
    pins = 11'h2C6;
    rd_seq(8'h83, 2, ok, idle);
    check8("R8 live reg3", rbuf[0], model(3));
    check8("R8 live reg4", rbuf[1], model(4));

    // R9 reset with fs=1, latches hold after pins change
    do_reset(1'b1, 1'b0, 3'd2);
    check8("R9 cfg0 reset fs=1", cfg0, 8'hF9);
    fs = 1'b0; bw = 1'b1;
    rd_seq(8'h84, 1, ok, idle);
    check8("R8 R9 latched reg4", rbuf[0], model(4));
    rd_seq(8'h87, 1, ok, idle);
    check8("R9 count reset", rbuf[0], 8'h07);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule